// File: doc/BRIEF.md
# Synthesizer Lock Status Register

This block keeps two sticky status bits about the lock state of a frequency synthesizer. A lock detector outside the block drives a single lock level. The block brings that level into its own clock domain, watches it for transitions, and records two events. One is a loss of lock, which can be captured either on each falling transition or as a level that stays asserted while lock is absent. The other is a gain of lock, captured on each rising transition.

Software reads both bits at once through a one-cycle read strobe. The read returns the current bits, and the block clears them on the edge that ends the read cycle, subject to the rules below. A separate reset-lock pulse clears the loss-of-lock bit. The two bits are ORed into one flag that a chip-level status and interrupt register can use.

Top module: `lock_status_reg`

## Requirements
- R1: After reset, `rd_data` is 2'b00 and `flag` is 0.
- R2: Edge mode (`oolk_level`=0) with `oolk_en`=1. The lock input passes through two synchronizing flip-flops. When `lock_in` falls, `rd_data[0]` (loss of lock) becomes 1 on the third rising clock edge that samples the low level. It is set once per falling transition.
- R3: In edge mode, a read (`rd_stb`=1 at an edge) clears `rd_data[0]` on that edge. The bit stays 0 while lock remains low.
- R4: While `oolk_en`=0, `rd_data[0]` is never set, in either mode.
- R5: Level mode (`oolk_level`=1) with `oolk_en`=1. `rd_data[0]` is 1 while the synchronized lock is 0, and a read at that time leaves it at 1.
- R6: In level mode, a read clears `rd_data[0]` when, at that edge, the synchronized lock is 1 or `oolk_en` is 0.
- R7: `rst_lock`=1 at an edge forces `rd_data[0]` to 0 on that edge. This overrides any set condition.
- R8: With `inlk_en`=1, `rd_data[1]` (in-lock) becomes 1 on the third edge after `lock_in` rises. A read clears it. With `inlk_en`=0 it is never set.
- R9: When a set condition and a read fall on the same edge, the bit is 1 after that edge. This holds for either bit.
- R10: `flag` equals `rd_data[1] | rd_data[0]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Lock level from the detector (asynchronous) |
| oolk_en | input | 1 | Enable for the loss-of-lock bit |
| oolk_level | input | 1 | Loss-of-lock mode: 0 = edge, 1 = level |
| inlk_en | input | 1 | Enable for the in-lock bit |
| rd_stb | input | 1 | Read strobe; clears bits on the edge that ends the cycle |
| rst_lock | input | 1 | Reset-lock pulse; clears the loss-of-lock bit |
| rd_data | output | 2 | Bit 1 in-lock, bit 0 loss-of-lock |
| flag | output | 1 | OR of both status bits |

## Verification
Two functions can fall on the same edge: the set of a status bit from a lock transition, and the clear from a read strobe. The bench provokes this by counting the two synchronizer stages and placing the read strobe on exactly the edge where a falling or rising lock is first seen. It then expects the bit to read 1 afterwards. The same approach places a reset-lock pulse on an edge where the level-mode set condition is true, and expects 0 there and 1 on the following edge.

// File: rtl/lock_status_pkg.sv
package lock_status_pkg;

    localparam int STAT_W    = 2;
    localparam int STAT_OOLK = 0;
    localparam int STAT_INLK = 1;

    typedef struct packed {
        logic inlk;
        logic oolk;
    } stat_t;

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic lock_s,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], lock_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_s = st_q.chain[STAGES-1];
    assign rise   = lock_s & ~st_q.prev;
    assign fall   = ~lock_s & st_q.prev;

endmodule

// File: rtl/oolk_flag.sv
module oolk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic fall,
    input  logic en,
    input  logic level,
    input  logic rd,
    input  logic clr,
    output logic bit_o
);

    typedef struct packed {
        logic hit;
    } oolk_t;

    oolk_t st_d, st_q;
    logic  set_c;

    always_comb begin
        set_c = en & (level ? ~lock_s : fall);
        st_d  = st_q;
        if (rd)    st_d.hit = 1'b0;
        if (set_c) st_d.hit = 1'b1;
        if (clr)   st_d.hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.hit;

    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && en && fall && !clr) |=> bit_o);

    p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level && rd && !(en && fall) && !clr) |=> !bit_o);

    p_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_o) |-> $past(en));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level && en && !lock_s && !clr) |=> bit_o);

    p_level_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level && rd && !clr && (lock_s || !en)) |=> !bit_o);

    p_rst_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !bit_o);

endmodule

// File: rtl/inlk_flag.sv
module inlk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic en,
    input  logic rd,
    output logic bit_o
);

    typedef struct packed {
        logic hit;
    } inlk_t;

    inlk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd)        st_d.hit = 1'b0;
        if (en & rise) st_d.hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.hit;

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_o) |-> $past(en && rise));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rise) |=> bit_o);

    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(en && rise)) |=> !bit_o);

endmodule

// File: rtl/lock_status_reg.sv
module lock_status_reg
    import lock_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_in,
    input  logic              oolk_en,
    input  logic              oolk_level,
    input  logic              inlk_en,
    input  logic              rd_stb,
    input  logic              rst_lock,
    output logic [STAT_W-1:0] rd_data,
    output logic              flag
);

    logic  lock_s, rise, fall;
    stat_t stat;

    lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_in(lock_in),
        .lock_s (lock_s),
        .rise   (rise),
        .fall   (fall)
    );

    oolk_flag u_oolk (
        .clk   (clk),
        .rst_n (rst_n),
        .lock_s(lock_s),
        .fall  (fall),
        .en    (oolk_en),
        .level (oolk_level),
        .rd    (rd_stb),
        .clr   (rst_lock),
        .bit_o (stat.oolk)
    );

    inlk_flag u_inlk (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (rise),
        .en   (inlk_en),
        .rd   (rd_stb),
        .bit_o(stat.inlk)
    );

    always_comb begin
        rd_data            = '0;
        rd_data[STAT_OOLK] = stat.oolk;
        rd_data[STAT_INLK] = stat.inlk;
    end

    assign flag = stat.oolk | stat.inlk;

    p_flag_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && !rise && !(oolk_en && fall) && !(oolk_en && oolk_level && !lock_s))
        |-> !flag);

endmodule

// File: tb/lock_status_reg_tb.sv
module lock_status_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_in = 1'b0, oolk_en = 1'b0, oolk_level = 1'b0, inlk_en = 1'b0;
    logic       rd_stb = 1'b0, rst_lock = 1'b0;
    logic [1:0] rd_data;
    logic       flag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur = "R1";

    always #4 clk = ~clk;

    lock_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .oolk_en(oolk_en),
        .oolk_level(oolk_level), .inlk_en(inlk_en), .rd_stb(rd_stb),
        .rst_lock(rst_lock), .rd_data(rd_data), .flag(flag)
    );

    // behavioural reference: a delay queue for the synchronizer
    bit syncq[$] = '{0, 0};
    bit m_prev = 0, m_oolk = 0, m_inlk = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syncq = '{0, 0};
            m_prev = 0; m_oolk = 0; m_inlk = 0;
        end else begin
            bit ls, fl, rs, so;
            ls = syncq[0];
            fl = m_prev && !ls;
            rs = !m_prev && ls;
            so = oolk_en && (oolk_level ? !ls : fl);
            if (rd_stb) begin m_oolk = 0; m_inlk = 0; end
            if (so) m_oolk = 1;
            if (inlk_en && rs) m_inlk = 1;
            if (rst_lock) m_oolk = 0;
            m_prev = ls;
            void'(syncq.pop_front());
            syncq.push_back(lock_in);
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            cycles++;
            chk(cur, rd_data, {m_inlk, m_oolk});
            chk("R10", flag, m_inlk | m_oolk);
        end
    endtask

    initial begin : watchdog
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #18;
        chk("R1", rd_data, 0);
        chk("R1", flag, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1", rd_data, 0);

        // in-lock set and read clear
        cur = "R8"; inlk_en = 1; lock_in = 1;
        step(2); chk("R8", rd_data[1], 0);
        step(1); chk("R8", rd_data[1], 1);
        rd_stb = 1; step(1); rd_stb = 0;
        chk("R8", rd_data[1], 0);
        inlk_en = 0;

        // edge mode loss of lock
        cur = "R2"; oolk_en = 1; oolk_level = 0; lock_in = 0;
        step(2); chk("R2", rd_data[0], 0);
        step(1); chk("R2", rd_data[0], 1);
        cur = "R3"; rd_stb = 1; step(1); rd_stb = 0;
        chk("R3", rd_data[0], 0);
        step(4); chk("R3", rd_data[0], 0);

        // enable off: no set in edge or level mode
        cur = "R4"; oolk_en = 0; lock_in = 1; step(4);
        lock_in = 0; step(5); chk("R4", rd_data[0], 0);
        oolk_level = 1; step(3); chk("R4", rd_data[0], 0);

        // level mode hold and read
        cur = "R5"; oolk_en = 1; step(1); chk("R5", rd_data[0], 1);
        rd_stb = 1; step(1); rd_stb = 0; chk("R5", rd_data[0], 1);
        cur = "R6"; lock_in = 1; step(3); chk("R6", rd_data[0], 1);
        rd_stb = 1; step(1); rd_stb = 0; chk("R6", rd_data[0], 0);
        lock_in = 0; step(3); chk("R5", rd_data[0], 1);
        oolk_en = 0; rd_stb = 1; step(1); rd_stb = 0;
        chk("R6", rd_data[0], 0);

        // reset-lock overrides a level set
        cur = "R7"; oolk_en = 1; step(2); chk("R7", rd_data[0], 1);
        rst_lock = 1; step(1); rst_lock = 0; chk("R7", rd_data[0], 0);
        step(1); chk("R7", rd_data[0], 1);
        oolk_en = 0; oolk_level = 0; rd_stb = 1; step(1); rd_stb = 0;
        lock_in = 1; step(4);

        // set and read on the same edge
        cur = "R9"; oolk_en = 1; lock_in = 0;
        step(2); rd_stb = 1; step(1); rd_stb = 0;
        chk("R9", rd_data[0], 1);
        inlk_en = 1; lock_in = 1;
        step(2); rd_stb = 1; step(1); rd_stb = 0;
        chk("R9", rd_data, 2'b10);
        chk("R10", flag, 1);
        rd_stb = 1; step(1); rd_stb = 0;
        chk("R10", flag, 0);

        // mixed pattern, compared every cycle
        cur = "R2";
        for (int k = 0; k < 60; k++) begin
            lock_in = (k % 7) < 3;
            rd_stb  = (k % 5) == 0;
            oolk_level = (k / 20) == 1;
            step(1);
        end
        rd_stb = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule